// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog countdown timer. It runs from a slow, free-running clock that is separate from the bus clock. Software reaches it through a simple four-word register interface. Writes to a key register unlock configuration, start the timer and refresh it. Two configuration registers set the countdown:

- a prescaler that selects a power-of-two divider of the slow clock;
- a 12-bit reload value that sets the starting count.

Configuration lives in the bus domain. Each accepted update crosses into the slow domain through a toggle handshake. A matching status bit stays set until the slow domain has taken the new value. If software stops refreshing, the down-counter reaches zero and the block raises its reset output for one slow-clock cycle. Once started, the timer cannot be stopped short of a system reset.

The expected programming sequence is:

1. Write the unlock key.
2. Write the prescaler and the reload value.
3. Write the start key.
4. Poll status until both update bits read zero.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the prescaler register (word 1) reads 0, the reload register (word 2) reads 0xFFF, the status register (word 3) reads 0, and `wdg_rst_o` is low.
- R2: Writing 0x5555 to the key register (word 0) opens writes to the prescaler and reload registers, and writing 0x0000 closes them. A write to either register while access is closed is ignored and leaves its read-back value unchanged.
- R3: A prescaler code n divides the slow clock by 2^(n+2), so code 0 gives a divide-by-4 tick. A written code above MAX_DIV_LOG2-2 is stored as MAX_DIV_LOG2-2 (6 for the default divider limit of 256).
- R4: The reload register holds 12 bits (0 to 0xFFF). While the timer runs unrefreshed, successive reset pulses are exactly (reload+1)×2^(n+2) slow-clock cycles apart.
- R5: Status bit 0 is set from the cycle after an accepted prescaler write, and status bit 1 from the cycle after an accepted reload write. Each bit clears once the slow domain has applied its value. A write to a register whose status bit is set is ignored.
- R6: Writing 0xCCCC to the key register starts the timer. No reset pulse occurs before start. After start, no key value stops the timer.
- R7: Writing 0xAAAA to the key register reloads the down-counter and restarts the prescaler, so a timer refreshed faster than its timeout never fires. The same write closes configuration access.
- R8: Each timeout produces a `wdg_rst_o` pulse exactly one slow-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both clock domains |
| clk_slow_i | input | 1 | Slow free-running watchdog clock |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable (valid with req_i) |
| addr_i | input | 2 | Word address: 0 key, 1 prescaler, 2 reload, 3 status |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| wdg_rst_o | output | 1 | Timeout reset pulse, slow-clock domain |

## Verification
The timeout is measured as the number of slow-clock cycles between successive reset pulses. It is measured for several prescaler and reload pairs:

- Divide-by-4 with reload 2 checks the basic formula.
- Divide-by-8 with reload 5 shows that the prescaler code is offset by two.
- An over-range code with reload 0 shows that the code is clamped.
- Divide-by-4 with reload 0xFFF checks the full 12-bit count.

A pattern of regular refreshes is set against the same setting left unrefreshed. This separates a counter that reloads from one that merely keeps counting. Writes made while locked, and a second write made while an update is still in flight, are distinguished from accepted writes by reading the registers back and polling the status bits.

// File: rtl/keyed_wdt_pkg.sv
`timescale 1ns/1ps
package keyed_wdt_pkg;
  localparam logic [15:0] KEY_UNLOCK = 16'h5555;
  localparam logic [15:0] KEY_LOCK   = 16'h0000;
  localparam logic [15:0] KEY_FEED   = 16'hAAAA;
  localparam logic [15:0] KEY_START  = 16'hCCCC;

  typedef enum logic [1:0] {
    REG_KEY  = 2'd0,
    REG_DIV  = 2'd1,
    REG_RLD  = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  // handshake channel index
  localparam int HS_DIV   = 0;
  localparam int HS_RLD   = 1;
  localparam int HS_START = 2;
  localparam int HS_FEED  = 3;
  localparam int HS_N     = 4;
endpackage

// File: rtl/keyed_wdt_hs.sv
`timescale 1ns/1ps
// Toggle request/acknowledge crossing; a request while busy merges into the pending one.
module keyed_wdt_hs #(
  parameter int STAGES = 2
) (
  input  logic clk_src_i,
  input  logic clk_dst_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o,
  output logic pulse_o
);
  logic              req_tgl_q;
  logic              seen_q;
  logic [STAGES-1:0] ack_sync_q;
  logic [STAGES-1:0] req_sync_q;

  assign busy_o  = req_tgl_q ^ ack_sync_q[STAGES-1];
  assign pulse_o = req_sync_q[STAGES-1] ^ seen_q;

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl_q  <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[STAGES-2:0], seen_q};
      if (req_i && !busy_o) req_tgl_q <= ~req_tgl_q;
    end
  end

  always_ff @(posedge clk_dst_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sync_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[STAGES-2:0], req_tgl_q};
      seen_q     <= req_sync_q[STAGES-1];
    end
  end
endmodule

// File: rtl/keyed_wdt_regs.sv
`timescale 1ns/1ps
module keyed_wdt_regs import keyed_wdt_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int RLD_W    = 12,
  parameter int DIV_W    = 3,
  parameter int MAX_CODE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              div_busy_i,
  input  logic              rld_busy_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [RLD_W-1:0]  rld_o,
  output logic              div_wr_o,
  output logic              rld_wr_o,
  output logic              start_o,
  output logic              feed_o,
  output logic              unlocked_o
);
  logic             wr;
  logic             key_wr;
  logic             unlocked_q;
  logic [DIV_W-1:0] div_q;
  logic [RLD_W-1:0] rld_q;
  logic [DIV_W-1:0] div_clamped;

  assign wr          = req_i & we_i;
  assign key_wr      = wr && (addr_i == REG_KEY);
  assign div_wr_o    = wr && (addr_i == REG_DIV) && unlocked_q && !div_busy_i;
  assign rld_wr_o    = wr && (addr_i == REG_RLD) && unlocked_q && !rld_busy_i;
  assign start_o     = key_wr && (wdata_i == DATA_W'(KEY_START));
  assign feed_o      = key_wr && (wdata_i == DATA_W'(KEY_FEED));
  assign div_clamped = (wdata_i > DATA_W'(MAX_CODE)) ? DIV_W'(MAX_CODE) : wdata_i[DIV_W-1:0];

  assign div_o      = div_q;
  assign rld_o      = rld_q;
  assign unlocked_o = unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      div_q      <= '0;
      rld_q      <= '1;
    end else begin
      if (key_wr) begin
        if (wdata_i == DATA_W'(KEY_UNLOCK))     unlocked_q <= 1'b1;
        else if (wdata_i == DATA_W'(KEY_LOCK))  unlocked_q <= 1'b0;
        else if (wdata_i == DATA_W'(KEY_FEED))  unlocked_q <= 1'b0;
      end
      if (div_wr_o) div_q <= div_clamped;
      if (rld_wr_o) rld_q <= wdata_i[RLD_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      REG_DIV:  rdata_o[DIV_W-1:0] = div_q;
      REG_RLD:  rdata_o[RLD_W-1:0] = rld_q;
      REG_STAT: rdata_o[1:0]       = {rld_busy_i, div_busy_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_core.sv
`timescale 1ns/1ps
module keyed_wdt_core #(
  parameter int MAX_DIV_LOG2 = 8,
  parameter int RLD_W        = 12,
  parameter int DIV_W        = 3,
  parameter int MAX_CODE     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [RLD_W-1:0] rld_i,
  input  logic             div_upd_i,
  input  logic             rld_upd_i,
  input  logic             start_i,
  input  logic             feed_i,
  output logic             running_o,
  output logic             wdg_rst_o
);
  localparam logic [MAX_DIV_LOG2-1:0] ONES = '1;

  logic [DIV_W-1:0]        div_s;
  logic [RLD_W-1:0]        rld_s;
  logic [RLD_W-1:0]        rld_nxt;
  logic [RLD_W-1:0]        cnt_q;
  logic [MAX_DIV_LOG2-1:0] pre_q;
  logic [MAX_DIV_LOG2-1:0] mask;
  logic                    running_q;
  logic                    fire_q;
  logic                    tick;
  logic                    load;

  assign mask    = ONES >> (MAX_CODE - int'(div_s));
  assign tick    = (pre_q & mask) == mask;
  assign rld_nxt = rld_upd_i ? rld_i : rld_s;
  assign load    = start_i || (feed_i && running_q);

  assign running_o = running_q;
  assign wdg_rst_o = fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_s     <= '0;
      rld_s     <= '1;
      cnt_q     <= '1;
      pre_q     <= '0;
      running_q <= 1'b0;
      fire_q    <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      rld_s  <= rld_nxt;
      if (div_upd_i) div_s <= div_i;
      if (load) begin
        running_q <= 1'b1;
        cnt_q     <= rld_nxt;
        pre_q     <= '0;
      end else if (running_q) begin
        pre_q <= pre_q + 1'b1;
        if (tick) begin
          if (cnt_q == '0) begin
            cnt_q  <= rld_nxt;
            fire_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt import keyed_wdt_pkg::*; #(
  parameter int MAX_DIV_LOG2 = 8,
  parameter int RLD_W        = 12,
  parameter int DATA_W       = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_slow_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdg_rst_o
);
  localparam int MAX_CODE = MAX_DIV_LOG2 - 2;
  localparam int DIV_W    = $clog2(MAX_CODE + 1);

  logic [DIV_W-1:0] div_q;
  logic [RLD_W-1:0] rld_q;
  logic [HS_N-1:0]  hs_req;
  logic [HS_N-1:0]  busy;
  logic [HS_N-1:0]  pulse;
  logic             unlocked;
  logic             running;

  keyed_wdt_regs #(
    .DATA_W(DATA_W), .RLD_W(RLD_W), .DIV_W(DIV_W), .MAX_CODE(MAX_CODE)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .div_busy_i (busy[HS_DIV]),
    .rld_busy_i (busy[HS_RLD]),
    .div_o      (div_q),
    .rld_o      (rld_q),
    .div_wr_o   (hs_req[HS_DIV]),
    .rld_wr_o   (hs_req[HS_RLD]),
    .start_o    (hs_req[HS_START]),
    .feed_o     (hs_req[HS_FEED]),
    .unlocked_o (unlocked)
  );

  for (genvar k = 0; k < HS_N; k++) begin : g_hs
    keyed_wdt_hs #(.STAGES(SYNC_STAGES)) u_hs (
      .clk_src_i (clk_i),
      .clk_dst_i (clk_slow_i),
      .rst_ni    (rst_ni),
      .req_i     (hs_req[k]),
      .busy_o    (busy[k]),
      .pulse_o   (pulse[k])
    );
  end

  keyed_wdt_core #(
    .MAX_DIV_LOG2(MAX_DIV_LOG2), .RLD_W(RLD_W), .DIV_W(DIV_W), .MAX_CODE(MAX_CODE)
  ) u_core (
    .clk_i     (clk_slow_i),
    .rst_ni    (rst_ni),
    .div_i     (div_q),
    .rld_i     (rld_q),
    .div_upd_i (pulse[HS_DIV]),
    .rld_upd_i (pulse[HS_RLD]),
    .start_i   (pulse[HS_START]),
    .feed_i    (pulse[HS_FEED]),
    .running_o (running),
    .wdg_rst_o (wdg_rst_o)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
`timescale 1ns/1ps
module keyed_wdt_chk #(
  parameter int RLD_W    = 12,
  parameter int DIV_W    = 3,
  parameter int MAX_CODE = 6,
  parameter int HS_N     = 4
) (
  input logic             clk_i,
  input logic             clk_slow_i,
  input logic             rst_ni,
  input logic             wdg_rst_i,
  input logic             running_i,
  input logic             unlocked_i,
  input logic             div_busy_i,
  input logic             rld_busy_i,
  input logic [DIV_W-1:0] div_q_i,
  input logic [RLD_W-1:0] rld_q_i,
  input logic [HS_N-1:0]  hs_req_i,
  input logic [HS_N-1:0]  hs_busy_i
);
  AST_LOCKED_RLD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> $stable(rld_q_i)); // R2
  AST_LOCKED_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> $stable(div_q_i)); // R2
  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(div_q_i) <= MAX_CODE); // R3
  AST_BUSY_RLD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rld_busy_i |=> $stable(rld_q_i)); // R5
  AST_BUSY_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy_i |=> $stable(div_q_i)); // R5
  for (genvar k = 0; k < HS_N; k++) begin : g_hs_chk
    AST_HS_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_busy_i[k]) |-> $past(hs_req_i[k])); // R5
  end
  AST_RUN_STICKY: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    running_i |=> running_i); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    !running_i |-> !wdg_rst_i); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    wdg_rst_i |=> !wdg_rst_i); // R8
endmodule

bind keyed_wdt keyed_wdt_chk #(
  .RLD_W(RLD_W), .DIV_W(DIV_W), .MAX_CODE(MAX_CODE), .HS_N(HS_N)
) u_chk (
  .clk_i      (clk_i),
  .clk_slow_i (clk_slow_i),
  .rst_ni     (rst_ni),
  .wdg_rst_i  (wdg_rst_o),
  .running_i  (running),
  .unlocked_i (unlocked),
  .div_busy_i (busy[0]),
  .rld_busy_i (busy[1]),
  .div_q_i    (div_q),
  .rld_q_i    (rld_q),
  .hs_req_i   (hs_req),
  .hs_busy_i  (busy)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  localparam logic [1:0] A_KEY = 2'd0, A_DIV = 2'd1, A_RLD = 2'd2, A_STAT = 2'd3;

  logic        clk = 1'b0;
  logic        clk_slow = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wdg_rst;

  int     errors = 0;
  int     checks = 0;
  int     exp_q[$];
  bit     have_ref = 1'b0;
  bit     prev_rst = 1'b0;
  bit     done = 1'b0;
  longint slow_cyc = 0;
  longint last_pulse = 0;
  int     pulse_cnt = 0;

  always #2.5 clk = ~clk;
  always #8 clk_slow = ~clk_slow;

  keyed_wdt u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .clk_slow_i (clk_slow),
    .req_i      (req),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .wdg_rst_o  (wdg_rst)
  );

  function automatic void chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endfunction

  // monitor: pulse width and scoreboard of pulse-to-pulse intervals
  always @(negedge clk_slow) begin
    slow_cyc++;
    if (rst_n) begin
      if (wdg_rst) begin
        pulse_cnt++;
        chk(!prev_rst, "R8 pulse wider than one slow cycle", 2, 1);
        if (exp_q.size() > 0) begin
          if (!have_ref) have_ref = 1'b1;
          else begin
            int e;
            e = exp_q.pop_front();
            chk((slow_cyc - last_pulse) == e, "R4 timeout interval", slow_cyc - last_pulse, e);
          end
        end
        last_pulse = slow_cyc;
      end
      prev_rst = wdg_rst;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(negedge clk_slow);
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] s;
    s = 16'hFFFF;
    for (int i = 0; i < 400; i++) begin
      bus_rd(A_STAT, s);
      if (s == 16'h0) break;
    end
    chk(s == 16'h0, tag, s, 0);
  endtask

  // driver: refresh, then push the expected interval and let the monitor consume it
  task automatic measure(input int code, input int rld, input string tag);
    int e;
    e = (rld + 1) << (code + 2);
    bus_wr(A_KEY, 16'hAAAA);
    wait_slow(8);
    have_ref = 1'b0;
    exp_q.push_back(e);
    while (exp_q.size() > 0) @(negedge clk);
    $display("  %s: interval %0d checked", tag, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hang expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int snap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(A_DIV, d);  chk(d == 16'h0,   "R1 prescaler reset", d, 0);
    bus_rd(A_RLD, d);  chk(d == 16'hFFF, "R1 reload reset", d, 16'hFFF);
    bus_rd(A_STAT, d); chk(d == 16'h0,   "R1 status reset", d, 0);
    chk(wdg_rst == 1'b0, "R1 reset output low", wdg_rst, 0);

    // R6 no pulse before start
    wait_slow(50);
    chk(pulse_cnt == 0, "R6 no pulse before start", pulse_cnt, 0);

    // R2 locked writes ignored
    bus_wr(A_RLD, 16'h0005);
    bus_wr(A_DIV, 16'h0003);
    bus_rd(A_RLD, d); chk(d == 16'hFFF, "R2 locked reload write ignored", d, 16'hFFF);
    bus_rd(A_DIV, d); chk(d == 16'h0,   "R2 locked prescaler write ignored", d, 0);

    // R2/R5 unlock, busy flags, write while busy
    bus_wr(A_KEY, 16'h5555);
    bus_wr(A_DIV, 16'h0000);
    bus_rd(A_STAT, d); chk(d[0] == 1'b1, "R5 prescaler busy bit set", d, 1);
    bus_wr(A_RLD, 16'h0002);
    bus_wr(A_RLD, 16'h0009);
    bus_rd(A_RLD, d);  chk(d == 16'h2, "R5 reload write while busy ignored", d, 2);
    bus_rd(A_STAT, d); chk(d[1] == 1'b1, "R5 reload busy bit set", d[1], 1);
    wait_idle("R5 status clears after apply");

    // R6 start, R4 timing 12 slow cycles
    bus_wr(A_KEY, 16'hCCCC);
    measure(0, 2, "R4 R6 div4 reload2");

    // R7 refresh relocked access
    bus_wr(A_RLD, 16'h0007);
    bus_rd(A_RLD, d); chk(d == 16'h2, "R7 refresh relocks writes", d, 2);

    // R3 code 1 -> divide by 8
    bus_wr(A_KEY, 16'h5555);
    bus_wr(A_DIV, 16'h0001);
    bus_wr(A_RLD, 16'h0005);
    wait_idle("R5 idle before div8");
    measure(1, 5, "R3 div8 reload5");

    // R3 clamp over-range code
    bus_wr(A_KEY, 16'h5555);
    bus_wr(A_DIV, 16'h0007);
    bus_wr(A_RLD, 16'h0000);
    wait_idle("R5 idle before clamp");
    bus_rd(A_DIV, d); chk(d == 16'h6, "R3 prescaler code clamped", d, 6);
    measure(6, 0, "R3 clamped div256 reload0");

    // R7 regular refresh prevents timeout
    bus_wr(A_KEY, 16'h5555);
    bus_wr(A_DIV, 16'h0000);
    bus_wr(A_RLD, 16'd20);
    wait_idle("R5 idle before refresh test");
    bus_wr(A_KEY, 16'hAAAA);
    wait_slow(8);
    snap = pulse_cnt;
    for (int i = 0; i < 10; i++) begin
      wait_slow(30);
      bus_wr(A_KEY, 16'hAAAA);
    end
    chk(pulse_cnt == snap, "R7 refreshed timer does not fire", pulse_cnt - snap, 0);
    measure(0, 20, "R7 R4 unrefreshed div4 reload20");

    // R6 no key stops the timer
    bus_wr(A_KEY, 16'h0000);
    bus_wr(A_KEY, 16'h1234);
    snap = pulse_cnt;
    wait_slow(200);
    chk(pulse_cnt > snap, "R6 timer keeps running after other keys", pulse_cnt - snap, 1);

    // R4 full 12-bit reload
    bus_wr(A_KEY, 16'h5555);
    bus_wr(A_RLD, 16'h0FFF);
    wait_idle("R5 idle before max reload");
    bus_rd(A_RLD, d); chk(d == 16'hFFF, "R4 max reload stored", d, 16'hFFF);
    measure(0, 16'hFFF, "R4 div4 reload 0xFFF");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule